// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides a local-oscillator signal by a programmable ratio N and emits one short pulse for every N cycles of that signal, for use as the feedback input of a phase detector. At lock the oscillator therefore runs at N times the comparison frequency. Two oscillator inputs are provided, a high band and a low band. Each arrives as a one-cycle strobe per input cycle, sampled in the block's clock domain.

A 16-bit ratio word and two mode bits set the division. In pulse-swallow operation the word is split into a 12-bit main count M (upper bits) and a 4-bit swallow count A (lower bits). A prescaler divides by 17 for the first A of its output cycles and by 16 for the rest of the M cycles, which gives N = 16·M + A. In direct operation only the upper 12 bits are used, as N = M, and the prescaler is bypassed. An inhibit input stops the divider. Ratio and mode are taken into the counters only when a period ends or while the divider is inhibited, so a change never produces a short period.

The controller has four states. HALT: inhibited, with counters reloaded every cycle. SWALLOW: the prescaler divides by 17 while the swallow count is non-zero. MAIN: the prescaler divides by 16. DIRECT: input strobes feed the main counter. The transitions are:
- Any running state goes to HALT when inhibit is high.
- HALT goes to the start state when inhibit falls.
- SWALLOW goes to MAIN on the prescaler wrap that exhausts the swallow count.
- Any running state goes to the start state at terminal count.

The start state is DIRECT for direct mode, MAIN when A = 0, and SWALLOW otherwise.

Top module: `divpre_swallow_divider`

## Requirements
- R1: After reset the output pulse is low, and no pulse is produced while no input strobe arrives.
- R2: With band_hi_i = 1 the divider counts hb_tick_i strobes in pulse-swallow mode with N = 16·ratio_i[15:4] + ratio_i[3:0], whatever the value of swallow_lo_i.
- R3: With band_hi_i = 0 and swallow_lo_i = 1 the divider counts lb_tick_i strobes in pulse-swallow mode with N = 16·ratio_i[15:4] + ratio_i[3:0], including the case ratio_i[3:0] = 0.
- R4: With band_hi_i = 0 and swallow_lo_i = 0 the divider counts lb_tick_i strobes with N = ratio_i[15:4], and ratio_i[3:0] has no effect.
- R5: Strobes on the input not selected by the mode in force are ignored.
- R6: div_pulse_o is high for exactly one clock cycle, in the cycle after the strobe that completes N strobes, and successive pulses are exactly N selected strobes apart.
- R7: A change of ratio_i or of the mode bits during a period takes effect only at the next terminal count. The current period completes with its old ratio and its old input.
- R8: While inhibit_i is high no pulse is produced. After it falls (one idle cycle) counting restarts from zero, and the first pulse follows N strobes.
- R9: The boundary ratios divide exactly: 272 and 65535 in pulse-swallow mode, 4 and 4095 in direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; input strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_tick_i | input | 1 | One-cycle strobe per high-band oscillator cycle |
| lb_tick_i | input | 1 | One-cycle strobe per low-band oscillator cycle |
| ratio_i | input | 16 | Division ratio word, bit 15 most significant |
| band_hi_i | input | 1 | 1 selects the high-band input with pulse-swallow division |
| swallow_lo_i | input | 1 | With band_hi_i = 0: 1 swallow mode, 0 direct 12-bit mode |
| inhibit_i | input | 1 | 1 stops the divider and suppresses the output |
| div_pulse_o | output | 1 | One-cycle pulse per N selected input strobes |

## Verification
The bench builds the block with its default widths: a 16-bit ratio with a 4-bit swallow field, so the prescaler switches between 16 and 17. These defaults make the full ratio range reachable in both swallow and direct modes, including 65535 and 4095. With them the bench can check both swallow phases, a zero swallow count and back-to-back periods, with strobes either continuous or spaced by idle cycles.

// File: rtl/divpre_pkg.sv
package divpre_pkg;

    // Controller states of the divider
    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,  // inhibited, counters follow the inputs
        ST_SWALLOW = 2'd1,  // prescaler divides by modulus + 1
        ST_MAIN    = 2'd2,  // prescaler divides by modulus
        ST_DIRECT  = 2'd3   // strobes feed the main counter directly
    } div_state_e;

endpackage

// File: rtl/divpre_prescaler.sv
module divpre_prescaler #(
    parameter int SWAL_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic mod_up,
    output logic tc
);
    localparam int PC_W = SWAL_W + 1;
    localparam logic [PC_W-1:0] LIM_LO = PC_W'((1 << SWAL_W) - 1);
    localparam logic [PC_W-1:0] LIM_HI = PC_W'(1 << SWAL_W);

    logic [PC_W-1:0] pc_q;

    assign tc = en && (pc_q == (mod_up ? LIM_HI : LIM_LO));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (clr) begin
            pc_q <= '0;
        end else if (en) begin
            pc_q <= tc ? '0 : pc_q + 1'b1;
        end
    end

    // R2: the extra count position is only reached under the long modulus
    a_r2_long_only_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q == LIM_HI) |-> mod_up);

endmodule

// File: rtl/divpre_downcnt.sv
module divpre_downcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/divpre_swallow_divider.sv
module divpre_swallow_divider
    import divpre_pkg::*;
#(
    parameter int RATIO_W = 16,
    parameter int SWAL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hb_tick_i,
    input  logic               lb_tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               band_hi_i,
    input  logic               swallow_lo_i,
    input  logic               inhibit_i,
    output logic               div_pulse_o
);
    localparam int MAIN_W = RATIO_W - SWAL_W;
    localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);
    localparam logic [SWAL_W-1:0] SWAL_ONE = SWAL_W'(1);

    div_state_e        state_q, state_d, start_st;
    logic              band_hi_q;
    logic              run, sel_tick, mod_up, pre_en, pre_clr, pre_tc;
    logic              cnt_event, at_end, load_en, new_swallow;
    logic [SWAL_W-1:0] scnt, new_a, scnt_load;
    logic [MAIN_W-1:0] mcnt, new_m;

    assign new_a       = ratio_i[SWAL_W-1:0];
    assign new_m       = ratio_i[RATIO_W-1:SWAL_W];
    assign new_swallow = band_hi_i | swallow_lo_i;
    assign scnt_load   = new_swallow ? new_a : '0;

    assign run       = (state_q != ST_HALT) && !inhibit_i;
    assign sel_tick  = band_hi_q ? hb_tick_i : lb_tick_i;
    assign mod_up    = (state_q == ST_SWALLOW);
    assign pre_en    = run && sel_tick && (state_q == ST_SWALLOW || state_q == ST_MAIN);
    assign cnt_event = (state_q == ST_DIRECT) ? (run && sel_tick) : pre_tc;
    assign at_end    = cnt_event && (mcnt == MAIN_ONE);
    assign load_en   = at_end || (state_q == ST_HALT);
    assign pre_clr   = load_en || !run;

    always_comb begin
        if (!new_swallow)       start_st = ST_DIRECT;
        else if (new_a == '0)   start_st = ST_MAIN;
        else                    start_st = ST_SWALLOW;
    end

    divpre_prescaler #(.SWAL_W(SWAL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pre_clr),
        .en     (pre_en),
        .mod_up (mod_up),
        .tc     (pre_tc)
    );

    divpre_downcnt #(.W(SWAL_W)) u_swal (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (scnt_load),
        .dec      (pre_tc && state_q == ST_SWALLOW),
        .cnt      (scnt)
    );

    divpre_downcnt #(.W(MAIN_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (new_m),
        .dec      (cnt_event),
        .cnt      (mcnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (!inhibit_i) state_d = start_st;
            end
            ST_SWALLOW: begin
                if (inhibit_i)                          state_d = ST_HALT;
                else if (at_end)                        state_d = start_st;
                else if (pre_tc && scnt == SWAL_ONE)    state_d = ST_MAIN;
            end
            ST_MAIN: begin
                if (inhibit_i)   state_d = ST_HALT;
                else if (at_end) state_d = start_st;
            end
            ST_DIRECT: begin
                if (inhibit_i)   state_d = ST_HALT;
                else if (at_end) state_d = start_st;
            end
        endcase
    end

    // state register and band selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_HALT;
            band_hi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_en) band_hi_q <= band_hi_i;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) div_pulse_o <= 1'b0;
        else        div_pulse_o <= at_end;
    end

    // R8: no pulse follows a cycle with inhibit high
    a_r8_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !div_pulse_o);

    // R7: input band only changes at a reload point
    a_r7_band_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_hi_q) |-> $past(load_en));

    // R6: every pulse is caused by a strobe in the previous cycle
    a_r6_pulse_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |-> $past(hb_tick_i || lb_tick_i));

    // R3: the short-modulus phase only runs with the swallow count exhausted
    a_r3_main_swal_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN) |-> (scnt == '0));

endmodule

// File: tb/divpre_swallow_divider_tb.sv
`timescale 1ns/1ps
module divpre_swallow_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_tick = 1'b0;
    logic        lb_tick = 1'b0;
    logic [15:0] ratio = 16'h0;
    logic        band_hi = 1'b0;
    logic        swallow_lo = 1'b0;
    logic        inhibit = 1'b0;
    logic        pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    divpre_swallow_divider u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hb_tick_i    (hb_tick),
        .lb_tick_i    (lb_tick),
        .ratio_i      (ratio),
        .band_hi_i    (band_hi),
        .swallow_lo_i (swallow_lo),
        .inhibit_i    (inhibit),
        .div_pulse_o  (pulse)
    );

    typedef struct packed {
        logic        dvs;
        logic        sns;
        logic [15:0] p;
        logic [16:0] n;
        logic        two;
        logic [1:0]  gap;
        logic        bnd;
    } vec_t;

    localparam vec_t TAB [8] = '{
        '{1'b1, 1'b0, 16'h0110, 17'd272,   1'b1, 2'd0, 1'b1},
        '{1'b1, 1'b1, 16'h0233, 17'd563,   1'b1, 2'd1, 1'b0},
        '{1'b0, 1'b1, 16'h0120, 17'd288,   1'b1, 2'd0, 1'b0},
        '{1'b0, 1'b1, 16'h01AF, 17'd431,   1'b1, 2'd2, 1'b0},
        '{1'b0, 1'b0, 16'h0040, 17'd4,     1'b1, 2'd0, 1'b1},
        '{1'b0, 1'b0, 16'h00C7, 17'd12,    1'b1, 2'd1, 1'b0},
        '{1'b0, 1'b0, 16'hFFF5, 17'd4095,  1'b1, 2'd0, 1'b1},
        '{1'b1, 1'b0, 16'hFFFF, 17'd65535, 1'b0, 2'd0, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic configure(input logic dvs, input logic sns, input logic [15:0] p);
        inhibit = 1'b1; band_hi = dvs; swallow_lo = sns; ratio = p;
        @(negedge clk); @(negedge clk);
        inhibit = 1'b0;
        @(negedge clk);
    endtask

    // send n strobes on one input; optional strobes on the other input
    task automatic pump(input logic use_hb, input logic noise, input int n, input int gap,
                        output int cnt, output int first, output int second, output int dbl);
        logic prev;
        prev = 1'b0; cnt = 0; first = 0; second = 0; dbl = 0;
        for (int i = 1; i <= n; i++) begin
            hb_tick = use_hb | noise;
            lb_tick = !use_hb | noise;
            @(negedge clk);
            hb_tick = 1'b0; lb_tick = 1'b0;
            if (pulse) begin
                if (prev) dbl++;
                cnt++;
                if (cnt == 1) first = i;
                else if (cnt == 2) second = i;
            end
            prev = pulse;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (pulse) begin cnt++; dbl++; end
                prev = pulse;
            end
        end
    endtask

    initial begin
        #950000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cnt, first, second, dbl, seen;
        string tag;

        // R1: reset state and quiet output without strobes
        repeat (4) @(negedge clk);
        chk(pulse == 1'b0, "R1", "pulse during reset", int'(pulse), 0);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pulse) seen++;
        end
        chk(seen == 0, "R1", "pulses without strobes", seen, 0);

        // vector table: R2/R3/R4 ratios, R5 noise on the other input, R6 period, R9 bounds
        for (int v = 0; v < 8; v++) begin
            tag = TAB[v].dvs ? "R2" : (TAB[v].sns ? "R3" : "R4");
            if (TAB[v].bnd) tag = {tag, "/R9"};
            configure(TAB[v].dvs, TAB[v].sns, TAB[v].p);
            pump(TAB[v].dvs, 1'b1, TAB[v].two ? 2 * int'(TAB[v].n) : int'(TAB[v].n),
                 int'(TAB[v].gap), cnt, first, second, dbl);
            chk(first == int'(TAB[v].n), {tag, "/R5"}, "first pulse strobe index",
                first, int'(TAB[v].n));
            if (TAB[v].two)
                chk(second - first == int'(TAB[v].n), {tag, "/R6"}, "pulse spacing",
                    second - first, int'(TAB[v].n));
            chk(dbl == 0, {tag, "/R6"}, "pulse wider than one cycle", dbl, 0);
        end

        // R7: ratio change mid-period waits for terminal count
        configure(1'b0, 1'b0, 16'h00A0);           // direct N=10
        pump(1'b0, 1'b0, 5, 0, cnt, first, second, dbl);
        chk(cnt == 0, "R7", "early pulse", cnt, 0);
        ratio = 16'h0060;                          // N=6
        pump(1'b0, 1'b0, 5, 0, cnt, first, second, dbl);
        chk(first == 5, "R7", "old period completes", first, 5);
        pump(1'b0, 1'b0, 6, 0, cnt, first, second, dbl);
        chk(first == 6, "R7", "new ratio after reload", first, 6);

        // R7: mode change mid-period keeps old input until terminal count
        configure(1'b0, 1'b0, 16'h00A0);
        pump(1'b0, 1'b0, 3, 0, cnt, first, second, dbl);
        band_hi = 1'b1; ratio = 16'h0110;          // swallow N=272 on high band
        pump(1'b0, 1'b0, 7, 0, cnt, first, second, dbl);
        chk(first == 7, "R7", "old band finishes period", first, 7);
        pump(1'b1, 1'b0, 272, 0, cnt, first, second, dbl);
        chk(first == 272, "R7", "new mode period", first, 272);

        // R5: low-band strobes alone have no effect in high-band mode
        pump(1'b0, 1'b0, 300, 0, cnt, first, second, dbl);
        chk(cnt == 0, "R5", "pulses from unselected input", cnt, 0);

        // R8: inhibit suppresses output and restarts counting
        configure(1'b0, 1'b0, 16'h0080);           // direct N=8
        pump(1'b0, 1'b0, 5, 0, cnt, first, second, dbl);
        inhibit = 1'b1;
        @(negedge clk);
        pump(1'b0, 1'b0, 20, 0, cnt, first, second, dbl);
        chk(cnt == 0, "R8", "pulses while inhibited", cnt, 0);
        inhibit = 1'b0;
        @(negedge clk);
        pump(1'b0, 1'b0, 8, 0, cnt, first, second, dbl);
        chk(first == 8, "R8", "first pulse after release", first, 8);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule